// File: doc/BRIEF.md
# Sparsifying Hit Data Combiner

This block gathers single-bit over-threshold flags from thirteen 32-channel front-end ports once per beam crossing. That gives a 416-channel hit map. The block discards every channel that did not fire. It turns the remaining channels into a list of channel addresses and wraps the list in a framed data block stamped with the crossing number. Blocks leave as a byte stream with a control-character flag, ready for a downstream 8B/10B encoder, under a valid/ready handshake.

A crossing strobe marks each new hit map, and the block keeps its own crossing counter. Crossings arrive every seven clock cycles. A four-entry crossing queue absorbs bursts of high occupancy, so one block may take longer than seven cycles to send. When the queue is full, the crossing is dropped and counted, and the next block that is accepted carries an overflow flag. Oversized hit lists are cut to 255 entries and marked as truncated.

Top module: `hit_combiner`

## Requirements
- R1: Each block is sent in this byte order:
  - control byte 0x3C, with `out_k_o` high;
  - a flag byte, where bit0 is overflow, bit1 is truncation and bits 7:2 are zero;
  - crossing number, high byte;
  - crossing number, low byte;
  - the hit count;
  - two bytes per hit;
  - control byte 0xBC, with `out_k_o` high.
  `out_k_o` is low on every other byte.
- R2: A hit's channel index is port×32+bit, which is its bit position in `hits_i`. The index is sent as the byte {7'b0, index[8]} followed by index[7:0]. Only set channels are sent, in strictly ascending index order.
- R3: A block's crossing number equals the number of strobes seen since reset before its own strobe, modulo 65536. Dropped crossings are included in that count.
- R4: A crossing with no hits still yields a six-byte block with a hit count of 0.
- R5: Up to four captured crossings wait behind the block being sent. A strobe that arrives while the queue is full is discarded, and `drop_cnt_o` increments, saturating at 255.
- R6: The overflow flag is set only in the block of the first crossing accepted after one or more dropped crossings.
- R7: A crossing with more than 255 hits reports a count of 255, sends its 255 lowest indices, and sets the truncation flag. A crossing with 255 or fewer hits has the truncation flag clear.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_k_o` hold steady.
- R9: After reset, `out_valid_o` is low, `drop_cnt_o` is 0 and the crossing counter is 0.
- R10: With `out_ready_i` held high, zero-hit crossings strobed every seven cycles are all sent and none is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xing_i | input | 1 | Crossing strobe; `hits_i` is captured on this cycle |
| hits_i | input | 416 | Hit map, port p on bits [p*32 +: 32] |
| out_ready_i | input | 1 | Downstream accepts the current byte |
| out_valid_o | output | 1 | Output byte is valid |
| out_data_o | output | 8 | Output byte |
| out_k_o | output | 1 | Output byte is a control character |
| drop_cnt_o | output | 8 | Saturating count of dropped crossings |

## Verification
The assertions check several behaviours on every cycle:
- the output holds still through backpressure;
- the control flag appears only on the two framing codes;
- the drop counter moves exactly when a strobe meets a full queue;
- the scanner never points at an empty map while it is sending hits.

Block contents need the bench's scenarios. These include the ascending address list, the crossing stamps and their wrap, truncation at 255 hits, and the overflow flag landing on the right block. Each is checked by rebuilding the expected block from the stored hit map of every strobed crossing.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam logic [7:0] K_SOB = 8'h3C;
  localparam logic [7:0] K_EOB = 8'hBC;
  localparam int FLAG_OVF   = 0;
  localparam int FLAG_TRUNC = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_SOB, S_FLG, S_XHI, S_XLO, S_CNT, S_HHI, S_HLO, S_EOB
  } fmt_state_e;
endpackage

// File: rtl/hc_popcount.sv
module hc_popcount #(
  parameter int N = 416
) (
  input  logic [N-1:0]           bits_i,
  output logic [$clog2(N+1)-1:0] count_o
);
  localparam int CW = $clog2(N + 1);

  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) count_o = count_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/hc_first_hit.sv
module hc_first_hit #(
  parameter int N = 416
) (
  input  logic [N-1:0]         bits_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IW = $clog2(N);

  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) if (bits_i[i]) idx_o = IW'(i);
  end
  assign found_o = |bits_i;
endmodule

// File: rtl/hc_xing_fifo.sv
module hc_xing_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         pop_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == CW'(DEPTH));
  assign do_push   = push_i && !full_o;
  assign do_pop    = pop_i && !empty_o;
  assign rd_data_o = mem[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) if (do_push) mem[wr_ptr_q] <= wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/hit_combiner.sv
module hit_combiner
  import hc_pkg::*;
#(
  parameter int NUM_PORTS  = 13,
  parameter int PORT_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int MAX_HITS   = 255,
  parameter int DROP_W     = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        xing_i,
  input  logic [NUM_PORTS*PORT_W-1:0] hits_i,
  input  logic                        out_ready_i,
  output logic                        out_valid_o,
  output logic [7:0]                  out_data_o,
  output logic                        out_k_o,
  output logic [DROP_W-1:0]           drop_cnt_o
);
  localparam int CH    = NUM_PORTS * PORT_W;
  localparam int IDX_W = $clog2(CH);
  localparam int CNT_W = $clog2(CH + 1);
  localparam int XN_W  = 16;
  localparam int ENT_W = 1 + CNT_W + XN_W + CH;

  // capture side
  logic [XN_W-1:0]   xnum_q;
  logic              ovf_pend_q;
  logic [DROP_W-1:0] drop_q;
  logic [CNT_W-1:0]  pop_cnt;
  logic              fifo_full, fifo_empty, push, drop, pop;
  logic [ENT_W-1:0]  wr_ent, rd_ent;

  hc_popcount #(.N(CH)) i_popcount (.bits_i(hits_i), .count_o(pop_cnt));

  assign push   = xing_i && !fifo_full;
  assign drop   = xing_i && fifo_full;
  assign wr_ent = {ovf_pend_q, pop_cnt, xnum_q, hits_i};

  hc_xing_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wr_data_i(wr_ent),
    .pop_i(pop), .rd_data_o(rd_ent),
    .empty_o(fifo_empty), .full_o(fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xnum_q     <= '0;
      ovf_pend_q <= 1'b0;
      drop_q     <= '0;
    end else begin
      if (xing_i) xnum_q <= xnum_q + 1'b1;
      if (drop) begin
        ovf_pend_q <= 1'b1;
        if (drop_q != '1) drop_q <= drop_q + 1'b1;
      end else if (push) begin
        ovf_pend_q <= 1'b0;
      end
    end
  end
  assign drop_cnt_o = drop_q;

  logic [CH-1:0]    rd_map;
  logic [XN_W-1:0]  rd_xn;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_ovf, rd_trunc;
  assign rd_map   = rd_ent[CH-1:0];
  assign rd_xn    = rd_ent[CH +: XN_W];
  assign rd_cnt   = rd_ent[CH+XN_W +: CNT_W];
  assign rd_ovf   = rd_ent[ENT_W-1];
  assign rd_trunc = rd_cnt > CNT_W'(MAX_HITS);

  // formatter
  fmt_state_e      state_q;
  logic [CH-1:0]   map_q;
  logic [XN_W-1:0] xn_q;
  logic [7:0]      cnt_q, sent_q;
  logic            ovf_q, trunc_q, fire, hit_found, in_hit;
  logic [IDX_W-1:0] hit_idx;

  hc_first_hit #(.N(CH)) i_first_hit (.bits_i(map_q), .found_o(hit_found), .idx_o(hit_idx));

  assign pop         = (state_q == S_IDLE) && !fifo_empty;
  assign out_valid_o = (state_q != S_IDLE);
  assign fire        = out_valid_o && out_ready_i;
  assign in_hit      = (state_q == S_HHI) || (state_q == S_HLO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      map_q   <= '0;
      xn_q    <= '0;
      cnt_q   <= '0;
      sent_q  <= '0;
      ovf_q   <= 1'b0;
      trunc_q <= 1'b0;
    end else if (pop) begin
      state_q <= S_SOB;
      map_q   <= rd_map;
      xn_q    <= rd_xn;
      cnt_q   <= rd_trunc ? 8'(MAX_HITS) : 8'(rd_cnt);
      sent_q  <= '0;
      ovf_q   <= rd_ovf;
      trunc_q <= rd_trunc;
    end else if (fire) begin
      unique case (state_q)
        S_SOB: state_q <= S_FLG;
        S_FLG: state_q <= S_XHI;
        S_XHI: state_q <= S_XLO;
        S_XLO: state_q <= S_CNT;
        S_CNT: state_q <= (cnt_q == '0) ? S_EOB : S_HHI;
        S_HHI: state_q <= S_HLO;
        S_HLO: begin
          map_q[hit_idx] <= 1'b0;
          sent_q  <= sent_q + 1'b1;
          state_q <= (sent_q + 8'd1 == cnt_q) ? S_EOB : S_HHI;
        end
        S_EOB: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    out_k_o    = 1'b0;
    out_data_o = '0;
    unique case (state_q)
      S_SOB: begin out_k_o = 1'b1; out_data_o = K_SOB; end
      S_FLG: begin
        out_data_o[FLAG_OVF]   = ovf_q;
        out_data_o[FLAG_TRUNC] = trunc_q;
      end
      S_XHI: out_data_o = xn_q[15:8];
      S_XLO: out_data_o = xn_q[7:0];
      S_CNT: out_data_o = cnt_q;
      S_HHI: out_data_o = 8'(hit_idx >> 8);
      S_HLO: out_data_o = hit_idx[7:0];
      S_EOB: begin out_k_o = 1'b1; out_data_o = K_EOB; end
      default: ;
    endcase
  end
endmodule

// File: rtl/hc_checker.sv
module hc_checker
  import hc_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xing_i,
  input logic              fifo_full,
  input logic              out_ready_i,
  input logic              out_valid_o,
  input logic [7:0]        out_data_o,
  input logic              out_k_o,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic              in_hit,
  input logic              hit_found
);
  a_r8_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_k_o));

  a_r1_k_only_framing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_k_o |-> (out_data_o == K_SOB) || (out_data_o == K_EOB));

  a_r5_drop_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xing_i && fifo_full && (drop_cnt_o != '1) |=> drop_cnt_o == DROP_W'($past(drop_cnt_o) + 1'b1));

  a_r5_count_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xing_i && fifo_full) |=> $stable(drop_cnt_o));

  a_r2_hit_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hit |-> hit_found);
endmodule

bind hit_combiner hc_checker #(.DROP_W(DROP_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xing_i(xing_i), .fifo_full(fifo_full),
  .out_ready_i(out_ready_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .out_k_o(out_k_o), .drop_cnt_o(drop_cnt_o), .in_hit(in_hit), .hit_found(hit_found)
);

// File: tb/test_hit_combiner.sv
module test_hit_combiner;
  import hc_pkg::*;
  localparam int CH = 416;

  logic          clk = 1'b0, rst_n = 1'b0, xing = 1'b0, rdy = 1'b0;
  logic [CH-1:0] hits = '0;
  logic          out_valid, out_k;
  logic [7:0]    out_data, drop_cnt;

  hit_combiner i_hit_combiner (
    .clk_i(clk), .rst_ni(rst_n), .xing_i(xing), .hits_i(hits),
    .out_ready_i(rdy), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_k_o(out_k), .drop_cnt_o(drop_cnt)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int rdy_pct = 100;
  int strobes = 0, blocks = 0, has_prev = 0, prev_xn = 0;
  logic [8:0]    bq[$];
  logic [CH-1:0] exp_map[int];

  // ready chosen first, then a transfer is logged for the coming edge
  always @(negedge clk) begin
    rdy = ($urandom_range(99) < rdy_pct);
    if (out_valid && rdy) bq.push_back({out_k, out_data});
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; xing = 1'b0; hits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strobes = 0; blocks = 0; has_prev = 0; prev_xn = 0;
    exp_map.delete();
    bq.delete();
    @(negedge clk);
  endtask

  task automatic strobe(input logic [CH-1:0] m);
    @(negedge clk);
    hits = m; xing = 1'b1;
    exp_map[strobes & 16'hFFFF] = m;
    strobes++;
    @(negedge clk);
    xing = 1'b0; hits = '0;
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) exp_map[(strobes + i) & 16'hFFFF] = '0;
    @(negedge clk);
    xing = 1'b1;
    repeat (n) @(negedge clk);
    xing = 1'b0;
    strobes += n;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (out_valid) q = 0; else q++;
    end
  endtask

  function automatic logic [8:0] pop_byte();
    if (bq.size() == 0) begin
      total++; bad++;
      $display("FAIL R1 stream ended inside a block actual=0 expected=1");
      return 9'h0;
    end
    return bq.pop_front();
  endfunction

  function automatic logic [CH-1:0] rand_map();
    logic [CH-1:0] m;
    for (int p = 0; p < 13; p++)
      m[p*32 +: 32] = $urandom & $urandom & $urandom & $urandom & $urandom;
    return m;
  endfunction

  task automatic parse_one();
    logic [8:0]    b, hi, lo;
    logic [CH-1:0] m;
    int xn, flags, cnt, pcount, exp_cnt, exp_ovf, p, idx;
    b = pop_byte();
    chk(b == {1'b1, K_SOB}, "R1 start code", b, {1'b1, K_SOB});
    b = pop_byte();
    chk(!b[8] && b[7:2] == 0, "R1 flag byte reserved", b, b & 9'h3);
    flags = b[1:0];
    hi = pop_byte(); lo = pop_byte();
    chk(!hi[8] && !lo[8], "R1 stamp bytes data", {hi[8], lo[8]}, 0);
    xn = {hi[7:0], lo[7:0]};
    chk(exp_map.exists(xn), "R3 stamp matches a strobed crossing", xn, xn);
    exp_ovf = has_prev ? (xn != ((prev_xn + 1) & 16'hFFFF)) : (xn != 0);
    chk(flags[FLAG_OVF] == exp_ovf, "R6 overflow flag", flags[FLAG_OVF], exp_ovf);
    m = exp_map.exists(xn) ? exp_map[xn] : '0;
    pcount  = $countones(m);
    exp_cnt = (pcount > 255) ? 255 : pcount;
    b = pop_byte();
    cnt = b[7:0];
    chk(!b[8] && cnt == exp_cnt, "R4/R7 hit count", cnt, exp_cnt);
    chk(flags[FLAG_TRUNC] == (pcount > 255), "R7 truncation flag", flags[FLAG_TRUNC], pcount > 255);
    p = 0;
    for (int i = 0; i < cnt; i++) begin
      hi = pop_byte(); lo = pop_byte();
      chk(!hi[8] && !lo[8] && hi[7:1] == 0, "R2 hit byte layout", hi, hi & 9'h1);
      idx = {hi[0], lo[7:0]};
      while (p < CH && !m[p]) p++;
      chk(idx == p, "R2 hit index ascending", idx, p);
      p++;
    end
    b = pop_byte();
    chk(b == {1'b1, K_EOB}, "R1 end code", b, {1'b1, K_EOB});
    has_prev = 1; prev_xn = xn; blocks++;
  endtask

  task automatic parse_all();
    while (bq.size() > 0) parse_one();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [CH-1:0] m;
    void'($urandom(32'd20240611));

    // R9 reset state
    do_reset();
    chk(out_valid == 1'b0, "R9 valid low after reset", out_valid, 0);
    chk(drop_cnt == 0, "R9 drop count zero after reset", drop_cnt, 0);

    // R10 / R4 sustained zero-hit crossings every seven cycles
    rdy_pct = 100;
    for (int i = 0; i < 20; i++) begin strobe('0); repeat (5) @(negedge clk); end
    wait_idle();
    parse_all();
    chk(blocks == 20, "R10 every crossing sent", blocks, 20);
    chk(drop_cnt == 0, "R10 no drops at full rate", drop_cnt, 0);
    chk(prev_xn == 19, "R3 first stamps count from zero", prev_xn, 19);

    // R2 directed channel corners
    do_reset();
    m = '0; m[0] = 1'b1;                       strobe(m); repeat (60) @(negedge clk);
    m = '0; m[CH-1] = 1'b1;                    strobe(m); repeat (60) @(negedge clk);
    m = '0; m[255] = 1'b1; m[256] = 1'b1;      strobe(m); repeat (60) @(negedge clk);
    m = '0; m[31] = 1'b1; m[32] = 1'b1; m[383] = 1'b1; strobe(m); repeat (60) @(negedge clk);
    m = '0; m[12*32 +: 32] = '1;               strobe(m); repeat (90) @(negedge clk);
    wait_idle();
    parse_all();
    chk(blocks == 5, "R2 directed blocks", blocks, 5);

    // R7 truncation boundaries: 255, 256, 416 hits
    m = '0; m[254:0] = '1; strobe(m); repeat (600) @(negedge clk);
    m = '0; m[255:0] = '1; strobe(m); repeat (600) @(negedge clk);
    strobe('1);            repeat (600) @(negedge clk);
    wait_idle();
    parse_all();
    chk(blocks == 8, "R7 truncation blocks", blocks, 8);

    // R5 / R6 random occupancy with backpressure
    do_reset();
    rdy_pct = 70;
    for (int i = 0; i < 80; i++) begin
      strobe(rand_map());
      repeat ($urandom_range(5, 30)) @(negedge clk);
    end
    wait_idle();
    parse_all();
    chk(drop_cnt == strobes - blocks, "R5 drops equal missing blocks", drop_cnt, strobes - blocks);

    // R5 / R6 / R8 directed overflow with output stalled
    do_reset();
    rdy_pct = 0;
    for (int i = 0; i < 7; i++) begin
      m = '0; m[i*10] = 1'b1; strobe(m); repeat (5) @(negedge clk);
    end
    chk(drop_cnt == 2, "R5 two crossings dropped", drop_cnt, 2);
    chk(out_valid == 1'b1 && bq.size() == 0, "R8 stalled output stays valid", out_valid, 1);
    rdy_pct = 100;
    wait_idle();
    m = '0; m[77] = 1'b1; strobe(m);
    wait_idle();
    parse_all();
    chk(blocks == 6, "R5 accepted blocks", blocks, 6);
    chk(prev_xn == 7, "R6 flagged block is crossing 7", prev_xn, 7);

    // R3 wrap and R5 saturation
    do_reset();
    rdy_pct = 0;
    burst(65536);
    chk(drop_cnt == 255, "R5 drop count saturates", drop_cnt, 255);
    rdy_pct = 100;
    wait_idle();
    parse_all();
    chk(blocks == 5, "R5 queued blocks after burst", blocks, 5);
    strobe('0);
    wait_idle();
    parse_all();
    chk(prev_xn == 0, "R3 stamp wraps modulo 65536", prev_xn, 0);

    finish_run();
  end
endmodule